// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM with a two-cycle data phase. An address and its command are captured on one rising edge, and the data that belongs to that command moves on the bus two clock edges later. The data moves in the same cycle slot whether the command is a read or a write. A write followed at once by a read, or a read followed at once by a write, therefore needs no idle cycle, and every clock can start a new transfer.

The memory array holds `2**ADDR_W` words. Each word is split into `LANES` lanes of `LANE_W` bits, and every lane has its own write enable. A two-bit burst counter lets a single loaded address produce up to four beats, in either sequential or XOR order. Three chip selects gate the start of new commands. An active-high `hold` freezes the whole pipeline. An asynchronous output enable can pull the bus drive low at any moment. The bidirectional data bus is split into `dq_in`, `dq_out` and `dq_oe`.

Top module: `zsram_zbt`

## Requirements
- R1: A read command accepted at edge N places the word on `dq_out` with `dq_oe` high after edge N+2, counting only edges where `hold` is low.
- R2: A write command accepted at edge N stores the value present on `dq_in` at edge N+2.
- R3: Reads and writes may be issued on consecutive edges in any mix, with no idle cycle, and each one returns or stores the correct word.
- R4: While `hold` is high, every input is ignored and the output drive, the output data, the pending commands and the array keep their values.
- R5: A new command starts only when `adv` is 0, `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0 (`rd_wr` 1 means read, 0 means write). With `adv` 0 and any select inactive, no command starts and the bus stays undriven for that slot.
- R6: A read already accepted still drives its data two edges after issue, even when the device is deselected in the cycles that follow.
- R7: `dq_oe` is low after edge N+2 when edge N carried a deselect or a write.
- R8: On a write, lane i (bits `[i*LANE_W +: LANE_W]`) is updated only when `lane_wen[i]` is 1. Other lanes keep their old content.
- R9: With `adv` 1 after an accepted load, the burst repeats the loaded direction. With `lin_order` 1, beat k uses low address bits `(base[1:0] + k) mod 4`, and the upper bits stay unchanged.
- R10: With `lin_order` 0, beat k of a burst uses low address bits `base[1:0] XOR k`.
- R11: `adv` 1 following a deselect starts nothing.
- R12: `oe_n` 1 forces `dq_oe` low at once, without waiting for a clock edge. While `oe_n` is 0, the drive follows the internal timing.
- R13: A read issued after a write to the same address returns the newest data. The newest data merges lane by lane any writes not yet committed to the array.
- R14: Reset clears all pending commands and disables the output drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 freezes the pipeline and ignores inputs |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 read, 0 write (sampled on load) |
| adv | input | 1 | 0 load new address, 1 advance burst |
| lin_order | input | 1 | 1 sequential burst, 0 XOR burst |
| addr | input | ADDR_W | Word address |
| lane_wen | input | LANES | Per-lane write enables, sampled with the command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data, two cycles after the command |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench targets a read that follows a write to the same word on the very next edge. A design that forgot to forward uncommitted write data would return the stale array word. The bench also merges two partial-lane writes back to back ahead of a read, which exposes a lane mask applied to the wrong bits. Holds are placed in the middle of both a read and a write in flight. A design that let any stage slip would shift the data by a cycle or capture the wrong `dq_in`. Sequential and XOR bursts start from offsets other than zero, to catch a carry out of the two-bit field or a swapped order. Deselects, stray advances and `oe_n` pulses are aimed at the drive slot, where a wrong design would drive the bus when it must not.

// File: rtl/zsram_pkg.sv
`timescale 1ns/1ps
package zsram_pkg;

    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_SEQ = 1'b1
    } burst_ord_e;

    // Low address bits for a given beat of a four-beat burst
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input burst_ord_e ord);
        return (ord == ORD_SEQ) ? 2'(start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/zsram_cmd.sv
`timescale 1ns/1ps
module zsram_cmd #(
    parameter int ADDR_W = 5,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              rd_wr,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wen,
    output logic              op_v,
    output logic              op_wr,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_mask
);
    import zsram_pkg::*;

    typedef struct packed {
        logic              act;
        logic              rd;
        logic [ADDR_W-1:0] base;
        logic [1:0]        beat;
        logic              v;
        logic              wr;
        logic [ADDR_W-1:0] a;
        logic [LANES-1:0]  m;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (!stall) begin
            cmd_d.m = lane_wen;
            if (!adv) begin
                if (sel_ok) begin
                    cmd_d.act  = 1'b1;
                    cmd_d.rd   = rd_wr;
                    cmd_d.base = addr;
                    cmd_d.beat = 2'd0;
                    cmd_d.v    = 1'b1;
                    cmd_d.wr   = ~rd_wr;
                    cmd_d.a    = addr;
                end else begin
                    cmd_d.act = 1'b0;
                    cmd_d.v   = 1'b0;
                    cmd_d.wr  = 1'b0;
                end
            end else if (cmd_q.act) begin
                cmd_d.beat = cmd_q.beat + 2'd1;
                cmd_d.v    = 1'b1;
                cmd_d.wr   = ~cmd_q.rd;
                cmd_d.a    = {cmd_q.base[ADDR_W-1:2],
                              beat_offset(cmd_q.base[1:0], cmd_q.beat + 2'd1,
                                          burst_ord_e'(lin_order))};
            end else begin
                cmd_d.v  = 1'b0;
                cmd_d.wr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign op_v    = cmd_q.v;
    assign op_wr   = cmd_q.wr;
    assign op_addr = cmd_q.a;
    assign op_mask = cmd_q.m;

    // R5
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv && !sel_ok) |=> !op_v);

    // R11
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && !cmd_q.act) |=> !op_v);

    // R9
    burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && cmd_q.act) |=>
            (op_v && op_addr[ADDR_W-1:2] == $past(cmd_q.base[ADDR_W-1:2])));

endmodule

// File: rtl/zsram_data.sv
`timescale 1ns/1ps
module zsram_data #(
    parameter int ADDR_W = 5,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall,
    input  logic                    op_v,
    input  logic                    op_wr,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic [LANES-1:0]        op_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic              p_v;
        logic              p_wr;
        logic [ADDR_W-1:0] p_a;
        logic [LANES-1:0]  p_m;
        logic              w_v;
        logic [ADDR_W-1:0] w_a;
        logic [LANES-1:0]  w_m;
        logic [DATA_W-1:0] w_d;
        logic              drv;
        logic [DATA_W-1:0] rd;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [DATA_W-1:0] merged;
    logic              hit;

    assign hit = dp_q.w_v && (dp_q.w_a == dp_q.p_a);

    // One storage bank per lane, with commit and bypass per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank_q [DEPTH];

        always_ff @(posedge clk) begin
            if (!stall && dp_q.w_v && dp_q.w_m[g])
                bank_q[dp_q.w_a] <= dp_q.w_d[g*LANE_W +: LANE_W];
        end

        assign merged[g*LANE_W +: LANE_W] = (hit && dp_q.w_m[g])
            ? dp_q.w_d[g*LANE_W +: LANE_W]
            : bank_q[dp_q.p_a];
    end

    always_comb begin
        dp_d = dp_q;
        if (!stall) begin
            dp_d.p_v  = op_v;
            dp_d.p_wr = op_wr;
            dp_d.p_a  = op_addr;
            dp_d.p_m  = op_mask;
            dp_d.w_v  = dp_q.p_v && dp_q.p_wr;
            dp_d.w_a  = dp_q.p_a;
            dp_d.w_m  = dp_q.p_m;
            dp_d.w_d  = wdata;
            dp_d.drv  = dp_q.p_v && !dp_q.p_wr;
            if (dp_q.p_v && !dp_q.p_wr)
                dp_d.rd = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign rdata = dp_q.rd;
    assign drive = dp_q.drv;

    // R7
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && dp_q.p_v && dp_q.p_wr) |=> !drive);

    // R6
    rd_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && dp_q.p_v && !dp_q.p_wr) |=> drive);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(rdata) && $stable(drive)));

endmodule

// File: rtl/zsram_zbt.sv
`timescale 1ns/1ps
module zsram_zbt #(
    parameter int ADDR_W = 5,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    rd_wr,
    input  logic                    adv,
    input  logic                    lin_order,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wen,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    logic              sel_ok;
    logic              op_v;
    logic              op_wr;
    logic [ADDR_W-1:0] op_addr;
    logic [LANES-1:0]  op_mask;
    logic              drive;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    zsram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (hold),
        .sel_ok    (sel_ok),
        .adv       (adv),
        .rd_wr     (rd_wr),
        .lin_order (lin_order),
        .addr      (addr),
        .lane_wen  (lane_wen),
        .op_v      (op_v),
        .op_wr     (op_wr),
        .op_addr   (op_addr),
        .op_mask   (op_mask)
    );

    zsram_data #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (hold),
        .op_v    (op_v),
        .op_wr   (op_wr),
        .op_addr (op_addr),
        .op_mask (op_mask),
        .wdata   (dq_in),
        .rdata   (dq_out),
        .drive   (drive)
    );

    assign dq_oe = drive && !oe_n;

endmodule

// File: tb/zsram_zbt_tb.sv
`timescale 1ns/1ps
module zsram_zbt_tb_top;
    localparam int AW = 5;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold = 1'b0;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          rd_wr = 1'b1, adv = 1'b0, lin_order = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_wen = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    zsram_zbt #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .rd_wr(rd_wr), .adv(adv), .lin_order(lin_order),
        .addr(addr), .lane_wen(lane_wen), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit            v;
        bit            wr;
        logic [AW-1:0] a;
        logic [LN-1:0] m;
        logic [DW-1:0] d;
        string         tg;
    } mop_t;

    typedef struct {
        int            edge_no;
        bit            drv;
        logic [DW-1:0] data;
        string         tg;
    } exp_t;

    exp_t          sbq[$];
    mop_t          m1, m2;
    logic [DW-1:0] ref_mem [1<<AW];
    bit            b_act, b_rd;
    logic [AW-1:0] b_base;
    logic [1:0]    b_beat;
    bit            last_drv;
    logic [DW-1:0] last_data;
    int            n_edges, mon_edges;
    int            checks, errors;
    bit            started, g_lin, g_oe_n;

    function automatic logic [DW-1:0] pat(input int i);
        return 36'h9_1357_2468 ^ (DW'(i) * 36'h0_0F1E_2D3C) ^ {4{LW'(i)}};
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic cyc(input bit st, input bit ad, input bit [2:0] ce, input bit rd,
                       input logic [AW-1:0] a, input logic [LN-1:0] m,
                       input logic [DW-1:0] wd, input string tg);
        mop_t       nop;
        exp_t       e;
        logic [1:0] off;
        hold = st; adv = ad; {sel_a_n, sel_b, sel_c_n} = ce; rd_wr = rd;
        addr = a; lane_wen = m; lin_order = g_lin; oe_n = g_oe_n;
        dq_in = (m2.v && m2.wr) ? m2.d : 36'hA_5A5A_5A5A;
        e.tg = tg;
        if (!st) begin
            if (m2.v && m2.wr) begin
                for (int i = 0; i < LN; i++)
                    if (m2.m[i]) ref_mem[m2.a][i*LW +: LW] = m2.d[i*LW +: LW];
                last_drv = 1'b0;
            end else if (m2.v) begin
                last_drv  = 1'b1;
                last_data = ref_mem[m2.a];
            end else begin
                last_drv = 1'b0;
            end
            if (m2.v) e.tg = m2.tg;
            nop.v = 1'b0; nop.wr = 1'b0; nop.a = a; nop.m = m; nop.d = wd; nop.tg = tg;
            if (!ad) begin
                if (ce == 3'b010) begin
                    b_act = 1'b1; b_rd = rd; b_base = a; b_beat = 2'd0;
                    nop.v = 1'b1; nop.wr = !rd;
                end else begin
                    b_act = 1'b0;
                end
            end else if (b_act) begin
                b_beat = b_beat + 2'd1;
                off    = g_lin ? 2'(b_base[1:0] + b_beat) : (b_base[1:0] ^ b_beat);
                nop.v  = 1'b1; nop.wr = !b_rd;
                nop.a  = {b_base[AW-1:2], off};
            end
            m2 = m1;
            m1 = nop;
        end
        n_edges++;
        e.edge_no = n_edges;
        e.drv     = last_drv;
        e.data    = last_data;
        sbq.push_back(e);
        @(posedge clk);
        #2;
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [LN-1:0] m,
                         input logic [DW-1:0] d, input string tg);
        cyc(1'b0, 1'b0, 3'b010, 1'b0, a, m, d, tg);
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input string tg);
        cyc(1'b0, 1'b0, 3'b010, 1'b1, a, '1, '0, tg);
    endtask

    task automatic do_adv(input logic [LN-1:0] m, input logic [DW-1:0] d, input string tg);
        cyc(1'b0, 1'b1, 3'b010, 1'b1, '0, m, d, tg);
    endtask

    task automatic do_hold(input string tg);
        // Would be a fully selected write to word 0 if it were not held
        cyc(1'b1, 1'b0, 3'b010, 1'b0, '0, '1, '0, tg);
    endtask

    task automatic do_desel(input bit [2:0] ce, input string tg);
        cyc(1'b0, 1'b0, ce, 1'b1, 5'd2, '1, '0, tg);
    endtask

    // Monitor: pops one expected item per edge and compares at the ports
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (started) begin
                mon_edges++;
                #13;
                if (sbq.size() > 0 && sbq[0].edge_no == mon_edges) begin
                    e = sbq.pop_front();
                    checks++;
                    if (dq_oe !== (e.drv && !oe_n)) begin
                        errors++;
                        $display("FAIL %s edge %0d dq_oe actual %b expected %b",
                                 (oe_n && e.drv) ? "R12" : e.tg, mon_edges, dq_oe, e.drv && !oe_n);
                    end
                    if (e.drv) begin
                        checks++;
                        if (dq_out !== e.data) begin
                            errors++;
                            $display("FAIL %s edge %0d dq_out actual %h expected %h",
                                     e.tg, mon_edges, dq_out, e.data);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        g_lin = 1'b1; g_oe_n = 1'b0;
        m1.v = 1'b0; m2.v = 1'b0; m1.wr = 1'b0; m2.wr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R14: drive is off during reset even with oe_n low
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R14 reset dq_oe actual %b expected 0", dq_oe);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R14 after reset dq_oe actual %b expected 0", dq_oe);
        end
        started = 1'b1;

        // R2: fill words 0..15
        for (int i = 0; i < 16; i++) do_wr(AW'(i), '1, pat(i), "R2");
        // R1: plain reads
        for (int i = 0; i < 4; i++) do_rd(AW'(i), "R1");
        // R3: alternate write / read each cycle
        for (int i = 0; i < 6; i++) begin
            do_wr(AW'(16 + i), '1, pat(100 + i), "R3");
            do_rd(AW'(i + 4), "R3");
        end
        for (int i = 0; i < 6; i++) do_rd(AW'(16 + i), "R3");
        // R13 / R8: read right behind writes to the same word
        do_wr(5'd20, '1, pat(200), "R13");
        do_rd(5'd20, "R13");
        do_wr(5'd20, 4'b0101, pat(201), "R8");
        do_rd(5'd20, "R8");
        do_wr(5'd20, 4'b1000, pat(202), "R13");
        do_wr(5'd20, 4'b0010, pat(203), "R13");
        do_rd(5'd20, "R13");
        // R4: holds with a read and a write in flight
        do_rd(5'd3, "R4");
        do_hold("R4"); do_hold("R4"); do_hold("R4");
        do_rd(5'd4, "R4");
        do_wr(5'd22, '1, pat(300), "R4");
        do_hold("R4"); do_hold("R4");
        do_rd(5'd22, "R4");
        do_rd(5'd0, "R4");
        // R5: each select inactive alone
        do_desel(3'b110, "R5");
        do_desel(3'b000, "R5");
        do_desel(3'b011, "R5");
        do_rd(5'd2, "R5");
        // R6 / R7: deselect after a read, then release
        do_rd(5'd7, "R6");
        do_desel(3'b110, "R6");
        do_desel(3'b110, "R7");
        do_wr(5'd23, '1, pat(350), "R7");
        do_desel(3'b110, "R7");
        // R11: advance with nothing loaded
        do_adv('1, pat(360), "R11");
        do_adv('1, pat(361), "R11");
        do_rd(5'd23, "R7");
        // R9: sequential read burst from offset 2
        g_lin = 1'b1;
        do_rd(5'd6, "R9");
        do_adv('1, '0, "R9"); do_adv('1, '0, "R9"); do_adv('1, '0, "R9");
        // R10: XOR read burst from offset 1
        g_lin = 1'b0;
        do_rd(5'd9, "R10");
        do_adv('1, '0, "R10"); do_adv('1, '0, "R10"); do_adv('1, '0, "R10");
        g_lin = 1'b1;
        // R9: sequential write burst, then read back
        do_wr(5'd26, '1, pat(400), "R9");
        do_adv('1, pat(401), "R9");
        do_adv(4'b0110, pat(402), "R9");
        do_adv('1, pat(403), "R9");
        for (int i = 24; i < 28; i++) do_rd(AW'(i), "R9");
        // R12: oe_n pulled high during a data slot
        do_rd(5'd1, "R12");
        do_rd(5'd2, "R12");
        do_rd(5'd3, "R12");
        g_oe_n = 1'b1;
        do_desel(3'b110, "R12");
        g_oe_n = 1'b0;
        do_desel(3'b110, "R12");
        for (int i = 0; i < 4; i++) do_desel(3'b110, "R7");

        while (sbq.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule